// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This block forms every memory address an 8-bit accumulator machine needs. A decoded request selects one of several addressing modes. A direct address byte can be passed straight through. Memory can be reached indirectly through one of two pointer registers, and that pointer can step up or down by one once the access is accepted. The accumulator can be joined to the upper program-counter bits to read a ROM table. A long jump can load the whole program counter. The pointers and the stack pointer also sit in the top sixteen data addresses, so an ordinary data write to those locations loads them.

Requests arrive on a valid/ready channel. A data-memory request is passed straight through to the data address channel, and a table read to the ROM address channel. No request is stored inside the block. The request channel's ready copies the ready of whichever channel the mode selects, so back-pressure from memory stalls the request. A pointer step or a PC load happens only on the clock edge where the request handshakes. Jumps and unused mode codes never stall.

Top module: `ptr_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets pointer B, pointer X and the PC to zero and the stack pointer to 0x6F.
- R2: Mode code 0 (direct) drives dmem_valid = req_valid and dmem_addr = req_dir, and makes req_ready follow dmem_ready. rom_valid stays low.
- R3: Mode codes 1 (through B) and 2 (through X) drive dmem_valid = req_valid and make req_ready follow dmem_ready. dmem_addr is the selected pointer's value before any step.
- R4: In modes 1 and 2, step code 1 adds one to the selected pointer and step code 2 subtracts one, both modulo 256. The step happens only on a handshake, with req_valid and req_ready both high. Step codes 0 and 3 leave the pointer unchanged. While the request is stalled, both pointers keep their values.
- R5: In mode 0 the step code has no effect on either pointer.
- R6: A register write (reg_wr_en high) loads the data into B at address 0xFE, into X at 0xFC, and into the stack pointer at 0xFD. A write to any other address leaves all three unchanged.
- R7: When a register write and a step target the same pointer in the same cycle, the written value wins.
- R8: Mode code 3 (table read) drives rom_valid = req_valid and rom_addr = {pc[14:8], req_acc}, and makes req_ready follow rom_ready. dmem_valid stays low.
- R9: Mode code 4 (long jump) is always ready and loads req_target into the PC on its handshake.
- R10: pc_adv high adds one to the PC modulo 32768. A jump handshake in the same cycle takes priority.
- R11: Mode codes 5 to 7 are always ready. They raise neither output valid and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_step | input | 2 | Pointer post-step code |
| req_dir | input | 8 | Direct address byte |
| req_acc | input | 8 | Accumulator value |
| req_target | input | 15 | Long jump target |
| dmem_valid | output | 1 | Data address valid |
| dmem_ready | input | 1 | Data memory accepts the address |
| dmem_addr | output | 8 | Data memory address |
| rom_valid | output | 1 | ROM table address valid |
| rom_ready | input | 1 | ROM accepts the address |
| rom_addr | output | 15 | ROM table address |
| reg_wr_en | input | 1 | Data write strobe |
| reg_wr_addr | input | 8 | Data write address |
| reg_wr_data | input | 8 | Data write value |
| pc_adv | input | 1 | Advance PC by one |
| ptr_b | output | 8 | Pointer B |
| ptr_x | output | 8 | Pointer X |
| ptr_sp | output | 8 | Stack pointer |
| pc | output | 15 | Program counter |

## Verification
The hardest case to reach is a stepping indirect access held off by data-memory back-pressure while a register write lands on the same pointer. If the precedence or the handshake gating is wrong, the pointer then moves to the wrong value. The bench drives this case directly: it stalls an incrementing B access at 0xFF, releases it so that B wraps to zero, and then overlaps a window write to 0xFE with a stepping B access. After that, a long randomized run with independent ready signals and frequent window writes compares a behavioural model with the outputs on every cycle.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;
  // addressing mode codes
  localparam logic [2:0] AM_DIRECT = 3'd0;
  localparam logic [2:0] AM_IND_B  = 3'd1;
  localparam logic [2:0] AM_IND_X  = 3'd2;
  localparam logic [2:0] AM_TABLE  = 3'd3;
  localparam logic [2:0] AM_JUMP   = 3'd4;
  // post-step codes
  localparam logic [1:0] ST_NONE = 2'd0;
  localparam logic [1:0] ST_INC  = 2'd1;
  localparam logic [1:0] ST_DEC  = 2'd2;
  // pointer table: B, X, SP
  localparam int NPTR   = 3;
  localparam int IDX_B  = 0;
  localparam int IDX_X  = 1;
  localparam int IDX_SP = 2;
  localparam int WIN_BITS = 4;
  localparam logic [WIN_BITS-1:0] PTR_OFS [NPTR] = '{4'hE, 4'hC, 4'hD};
  localparam logic [7:0] SP_RESET = 8'h6F;
endpackage

// File: rtl/dag_ptr_reg.sv
module dag_ptr_reg #(
  parameter int W = 8,
  parameter int OW = 4,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter logic [OW-1:0] OFS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win_wr,
  input  logic [OW-1:0] win_ofs,
  input  logic [W-1:0]  win_data,
  input  logic          step_fire,
  input  logic          step_dec,
  output logic [W-1:0]  value
);
  logic wr_hit;
  assign wr_hit = win_wr && (win_ofs == OFS);

  // explicit write has priority over the post-step
  always_ff @(posedge clk) begin
    if (rst)            value <= RST_VAL;
    else if (wr_hit)    value <= win_data;
    else if (step_fire) value <= step_dec ? value - 1'b1 : value + 1'b1;
  end
endmodule

// File: rtl/dag_pc.sv
module dag_pc #(
  parameter int PCW = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [PCW-1:0] target,
  input  logic           adv,
  output logic [PCW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= target;
    else if (adv)  pc <= pc + 1'b1;
  end
endmodule

// File: rtl/dag_route.sv
module dag_route
  import ptr_addr_pkg::*;
#(
  parameter int DW = 8,
  parameter int PCW = 15
) (
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic [1:0]        req_step,
  input  logic [DW-1:0]     req_dir,
  input  logic [DW-1:0]     req_acc,
  input  logic [PCW-DW-1:0] pc_hi,
  input  logic [DW-1:0]     cur_b,
  input  logic [DW-1:0]     cur_x,
  input  logic              dmem_ready,
  input  logic              rom_ready,
  output logic              req_ready,
  output logic              dmem_valid,
  output logic [DW-1:0]     dmem_addr,
  output logic              rom_valid,
  output logic [PCW-1:0]    rom_addr,
  output logic              step_b,
  output logic              step_x,
  output logic              step_dec,
  output logic              jump_fire
);
  logic stepping;
  assign stepping = (req_step == ST_INC) || (req_step == ST_DEC);
  assign step_dec = (req_step == ST_DEC);
  assign rom_addr = {pc_hi, req_acc};

  always_comb begin
    req_ready  = 1'b1;
    dmem_valid = 1'b0;
    dmem_addr  = req_dir;
    rom_valid  = 1'b0;
    step_b     = 1'b0;
    step_x     = 1'b0;
    jump_fire  = 1'b0;
    case (req_mode)
      AM_DIRECT: begin
        dmem_valid = req_valid;
        req_ready  = dmem_ready;
      end
      AM_IND_B: begin
        dmem_valid = req_valid;
        dmem_addr  = cur_b;
        req_ready  = dmem_ready;
        step_b     = req_valid && dmem_ready && stepping;
      end
      AM_IND_X: begin
        dmem_valid = req_valid;
        dmem_addr  = cur_x;
        req_ready  = dmem_ready;
        step_x     = req_valid && dmem_ready && stepping;
      end
      AM_TABLE: begin
        rom_valid = req_valid;
        req_ready = rom_ready;
      end
      AM_JUMP:  jump_fire = req_valid;
      default:  ;
    endcase
  end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_addr_pkg::*;
#(
  parameter int DW = 8,
  parameter int PCW = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     req_mode,
  input  logic [1:0]     req_step,
  input  logic [DW-1:0]  req_dir,
  input  logic [DW-1:0]  req_acc,
  input  logic [PCW-1:0] req_target,
  output logic           dmem_valid,
  input  logic           dmem_ready,
  output logic [DW-1:0]  dmem_addr,
  output logic           rom_valid,
  input  logic           rom_ready,
  output logic [PCW-1:0] rom_addr,
  input  logic           reg_wr_en,
  input  logic [DW-1:0]  reg_wr_addr,
  input  logic [DW-1:0]  reg_wr_data,
  input  logic           pc_adv,
  output logic [DW-1:0]  ptr_b,
  output logic [DW-1:0]  ptr_x,
  output logic [DW-1:0]  ptr_sp,
  output logic [PCW-1:0] pc
);
  localparam int PCHI = PCW - DW;
  localparam logic [DW-1:0] PTR_RST [NPTR] = '{'0, '0, DW'(SP_RESET)};

  logic [DW-1:0]   ptr_q [NPTR];
  logic [NPTR-1:0] step_fire;
  logic            step_dec;
  logic            jump_fire;
  logic            win_wr;

  // the register window is the top 2**WIN_BITS data addresses
  assign win_wr = reg_wr_en && (&reg_wr_addr[DW-1:WIN_BITS]);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dag_ptr_reg #(
      .W(DW), .OW(WIN_BITS), .RST_VAL(PTR_RST[g]), .OFS(PTR_OFS[g])
    ) u_ptr (
      .clk       (clk),
      .rst       (rst),
      .win_wr    (win_wr),
      .win_ofs   (reg_wr_addr[WIN_BITS-1:0]),
      .win_data  (reg_wr_data),
      .step_fire (step_fire[g]),
      .step_dec  (step_dec),
      .value     (ptr_q[g])
    );
  end

  assign step_fire[IDX_SP] = 1'b0;

  dag_route #(.DW(DW), .PCW(PCW)) u_route (
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_step   (req_step),
    .req_dir    (req_dir),
    .req_acc    (req_acc),
    .pc_hi      (pc[PCW-1:PCW-PCHI]),
    .cur_b      (ptr_q[IDX_B]),
    .cur_x      (ptr_q[IDX_X]),
    .dmem_ready (dmem_ready),
    .rom_ready  (rom_ready),
    .req_ready  (req_ready),
    .dmem_valid (dmem_valid),
    .dmem_addr  (dmem_addr),
    .rom_valid  (rom_valid),
    .rom_addr   (rom_addr),
    .step_b     (step_fire[IDX_B]),
    .step_x     (step_fire[IDX_X]),
    .step_dec   (step_dec),
    .jump_fire  (jump_fire)
  );

  dag_pc #(.PCW(PCW)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .load   (jump_fire),
    .target (req_target),
    .adv    (pc_adv),
    .pc     (pc)
  );

  assign ptr_b  = ptr_q[IDX_B];
  assign ptr_x  = ptr_q[IDX_X];
  assign ptr_sp = ptr_q[IDX_SP];
endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk
  import ptr_addr_pkg::*;
#(
  parameter int DW = 8,
  parameter int PCW = 15
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic [2:0]     req_mode,
  input logic [1:0]     req_step,
  input logic [DW-1:0]  req_dir,
  input logic [DW-1:0]  req_acc,
  input logic [PCW-1:0] req_target,
  input logic           dmem_valid,
  input logic           dmem_ready,
  input logic [DW-1:0]  dmem_addr,
  input logic           rom_valid,
  input logic [PCW-1:0] rom_addr,
  input logic           reg_wr_en,
  input logic           pc_adv,
  input logic [DW-1:0]  ptr_b,
  input logic [DW-1:0]  ptr_x,
  input logic [PCW-1:0] pc
);
  logic hs;
  assign hs = req_valid && req_ready;

  a_r2_direct_path: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_DIRECT) |->
      (dmem_valid && dmem_addr == req_dir && req_ready == dmem_ready && !rom_valid));

  a_r3_ptr_b_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_IND_B) |-> (dmem_valid && dmem_addr == ptr_b));

  a_r4_b_inc: assert property (@(posedge clk) disable iff (rst)
    (hs && req_mode == AM_IND_B && req_step == ST_INC && !reg_wr_en) |=>
      (ptr_b == DW'($past(ptr_b) + 1'b1)));

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (!hs && !reg_wr_en) |=> ($stable(ptr_b) && $stable(ptr_x)));

  a_r8_one_channel: assert property (@(posedge clk) disable iff (rst)
    !(dmem_valid && rom_valid));

  a_r8_table_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == AM_TABLE) |->
      (rom_valid && rom_addr == {pc[PCW-1:DW], req_acc}));

  a_r9_jump_load: assert property (@(posedge clk) disable iff (rst)
    (hs && req_mode == AM_JUMP) |=> (pc == $past(req_target)));

  a_r10_advance: assert property (@(posedge clk) disable iff (rst)
    (!(hs && req_mode == AM_JUMP) && pc_adv) |=> (pc == PCW'($past(pc) + 1'b1)));

  a_r11_unused_mode: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode > AM_JUMP) |-> (req_ready && !dmem_valid && !rom_valid));
endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(.DW(DW), .PCW(PCW)) u_chk (.*);

// File: tb/tb_ptr_addr_gen.sv
module tb_ptr_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, dmem_ready = 0, rom_ready = 0, reg_wr_en = 0, pc_adv = 0;
  logic [2:0]  req_mode = 0;
  logic [1:0]  req_step = 0;
  logic [7:0]  req_dir = 0, req_acc = 0, reg_wr_addr = 0, reg_wr_data = 0;
  logic [14:0] req_target = 0;
  logic        req_ready, dmem_valid, rom_valid;
  logic [7:0]  dmem_addr, ptr_b, ptr_x, ptr_sp;
  logic [14:0] rom_addr, pc;

  int n_checks = 0;
  int n_errors = 0;
  int m_b = 0, m_x = 0, m_sp = 'h6F, m_pc = 0;

  always #5 clk = ~clk;

  ptr_addr_gen dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: drive, compare against the model, advance the model
  task automatic cyc(input bit v, input int mode, input int step, input int dir,
                     input int acc, input int tgt, input bit dr, input bit rr,
                     input bit we, input int wa, input int wd, input bit adv);
    string t;
    bit exp_rdy, hs, dv, rv;
    int nb, nx, nsp, npc;
    @(negedge clk);
    req_valid = v; req_mode = 3'(mode); req_step = 2'(step); req_dir = 8'(dir);
    req_acc = 8'(acc); req_target = 15'(tgt); dmem_ready = dr; rom_ready = rr;
    reg_wr_en = we; reg_wr_addr = 8'(wa); reg_wr_data = 8'(wd); pc_adv = adv;
    #1;
    chk("R4 ptr_b", ptr_b, m_b);
    chk("R4 ptr_x", ptr_x, m_x);
    chk("R6 ptr_sp", ptr_sp, m_sp);
    chk("R10 pc", pc, m_pc);
    dv = 0; rv = 0; exp_rdy = 1;
    if (mode == 0) begin t = "R2"; dv = v; exp_rdy = dr; end
    else if (mode <= 2) begin t = "R3"; dv = v; exp_rdy = dr; end
    else if (mode == 3) begin t = "R8"; rv = v; exp_rdy = rr; end
    else if (mode == 4) t = "R9";
    else t = "R11";
    chk({t, " req_ready"}, req_ready, exp_rdy);
    chk({t, " dmem_valid"}, dmem_valid, dv);
    chk({t, " rom_valid"}, rom_valid, rv);
    if (dv) chk({t, " dmem_addr"}, dmem_addr, mode == 0 ? dir : (mode == 1 ? m_b : m_x));
    if (rv) chk("R8 rom_addr", rom_addr, ((m_pc >> 8) << 8) | acc);
    hs = v && exp_rdy;
    nb = m_b; nx = m_x; nsp = m_sp; npc = m_pc;
    if (hs && (step == 1 || step == 2)) begin
      if (mode == 1) nb = (m_b + (step == 1 ? 1 : 255)) % 256;
      if (mode == 2) nx = (m_x + (step == 1 ? 1 : 255)) % 256;
    end
    if (we && wa == 'hFE) nb = wd;
    if (we && wa == 'hFC) nx = wd;
    if (we && wa == 'hFD) nsp = wd;
    if (hs && mode == 4) npc = tgt;
    else if (adv) npc = (m_pc + 1) % 32768;
    @(posedge clk);
    m_b = nb; m_x = nx; m_sp = nsp; m_pc = npc;
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset b", ptr_b, 0);
    chk("R1 reset x", ptr_x, 0);
    chk("R1 reset sp", ptr_sp, 'h6F);
    chk("R1 reset pc", pc, 0);
    rst = 1'b0;
    // direct, stalled then accepted
    cyc(1, 0, 0, 'h37, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 'h37, 0, 0, 1, 0, 0, 0, 0, 0);
    // window writes, including a non-pointer address
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 'hFE, 'hFF, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 'hFC, 'h00, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 'hFD, 'h42, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 'hF0, 'h99, 0);
    chk("R6 other address ignored b", ptr_b, 'hFF);
    chk("R6 other address ignored sp", ptr_sp, 'h42);
    // stalled B increment, then released: wrap to zero
    cyc(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 stall holds b", ptr_b, 'hFF);
    cyc(1, 1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R4 b wraps up", ptr_b, 'h00);
    cyc(1, 2, 2, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R4 x wraps down", ptr_x, 'hFF);
    // direct access with a step code
    cyc(1, 0, 1, 'h12, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R5 direct step ignored b", ptr_b, 'h00);
    chk("R5 direct step ignored x", ptr_x, 'hFF);
    // write and step collide on B
    cyc(1, 1, 1, 0, 0, 0, 1, 0, 1, 'hFE, 'h10, 0);
    chk("R7 write wins", ptr_b, 'h10);
    // jump with advance, then table read
    cyc(1, 4, 0, 0, 0, 'h7F12, 0, 0, 0, 0, 0, 1);
    chk("R9 jump target", pc, 'h7F12);
    chk("R10 jump beats advance", pc, 'h7F12);
    cyc(1, 3, 0, 0, 'hA5, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 3, 0, 0, 'hA5, 0, 0, 1, 0, 0, 0, 0);
    cyc(1, 4, 0, 0, 0, 'h7FFF, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 pc wraps", pc, 0);
    // unused mode with a step request
    cyc(1, 6, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 unused mode b", ptr_b, 'h10);
    // randomized run
    for (int i = 0; i < 3000; i++) begin
      int wa;
      wa = ($urandom % 2) ? ('hFC + $urandom % 4) : ($urandom % 256);
      cyc($urandom % 4 != 0, $urandom % 8, $urandom % 4, $urandom % 256,
          $urandom % 256, $urandom % 32768, $urandom % 2, $urandom % 2,
          $urandom % 4 == 0, wa, $urandom % 256, $urandom % 3 == 0);
    end
    finish_run();
  end
endmodule